// File: doc/BRIEF.md
# Interrupt-Level Cache Lock Controller

This block is the control and status unit for a split cache whose lock state follows the processor's live interrupt level. Software programs a per-level lock mask with one bit for each interrupt level. The block takes the current 3-bit level as an input and indexes the mask with it. The selected bit, gated by each cache's own enable, becomes the lock signal for the instruction cache and for the data cache. A locked cache must not refill: the cache logic outside this block serves misses straight from external memory and does not allocate them.

Because the lock is re-evaluated from the level every cycle, it drops when a nested interrupt raises the level to one whose mask bit is clear. It engages again when that handler returns, and software does nothing in either case. The lock applies the same way whether or not the core is halted for debug. A small word-addressed register bank holds three things: the configuration bits (cache enables, write-buffer enable, software-break enable), the lock mask, and a read-only status word that reports both lock signals. The configuration bits are also exported as pins.

Top module: `cache_lock_ctrl`

## Requirements
- R1: After reset the configuration register at offset 0x00 reads 0x0000_0104, the mask register at 0x08 reads 0, and the status register at 0x0C reads 0. wbuf_en and swbrk_en are 1, and icache_en, dcache_en, icache_lock and dcache_lock are 0.
- R2: A write to offset 0x00 stores only bit 8 (write-buffer enable), bit 2 (software-break enable), bit 1 (instruction-cache enable) and bit 0 (data-cache enable). Every other bit of that register reads 0.
- R3: The pins wbuf_en, swbrk_en, icache_en and dcache_en always equal configuration bits 8, 2, 1 and 0 in that order.
- R4: A write to offset 0x08 stores bits [7:0] as the lock mask, with bit n belonging to interrupt level n. Bits [31:8] of that register read 0.
- R5: icache_lock equals icache_en AND mask[int_level]. dcache_lock equals dcache_en AND mask[int_level].
- R6: When int_level changes and no register write takes place, both lock outputs follow the newly indexed mask bit in the same cycle. Raising the level to one whose bit is clear releases the lock, and returning to the earlier level restores it.
- R7: A mask of 0xFF locks every enabled cache at all eight levels. A mask of 0x00 leaves both caches unlocked at all eight levels.
- R8: At offset 0x0C, bit 1 reads icache_lock, bit 0 reads dcache_lock, and all other bits read 0. Writes to that offset change no register.
- R9: Reads of any offset other than 0x00, 0x08 and 0x0C return 0, including 0x04, 0x18 and 0x60. Writes to those offsets change no register.
- R10: A cache whose enable bit is 0 reports unlocked, on both its pin and its status bit, whatever the mask and the level.
- R11: A mask write takes effect at the clock edge that samples the write strobe. Before that edge the lock outputs still reflect the old mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W (8) | Byte offset of the register accessed |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from bus_addr |
| int_level | input | LEVEL_W (3) | Current interrupt level of the core |
| icache_en | output | 1 | Instruction cache enable |
| dcache_en | output | 1 | Data cache enable |
| wbuf_en | output | 1 | Write buffer enable |
| swbrk_en | output | 1 | Software break enable |
| icache_lock | output | 1 | Instruction cache locked, so refills are suppressed |
| dcache_lock | output | 1 | Data cache locked, so refills are suppressed |

## Verification
The bench builds the block with its default parameters: 3 level bits, which give eight levels and an eight-bit mask, an 8-bit offset and 32-bit data. With eight levels, every level can be swept exhaustively against random masks. The 8-bit offset reaches every mapped register and the unmapped offsets 0x04, 0x18 and 0x60. At this size, nested-interrupt level changes and the edge at which a mask write lands can both be observed directly at the pins.

// File: rtl/cache_lock_pkg.sv
`timescale 1ns/1ps
package cache_lock_pkg;

    // Register offsets (bytes)
    localparam int OFF_CFG   = 'h00;
    localparam int OFF_MASK  = 'h08;
    localparam int OFF_STAT  = 'h0C;

    // Configuration bit positions
    localparam int CFG_WB_POS = 8;
    localparam int CFG_SB_POS = 2;
    localparam int CFG_IC_POS = 1;
    localparam int CFG_DC_POS = 0;

    // Status bit positions
    localparam int STAT_IC_POS = 1;
    localparam int STAT_DC_POS = 0;

    // Cache indices on the lock vector
    localparam int CACHE_D   = 0;
    localparam int CACHE_I   = 1;
    localparam int N_CACHES  = 2;

    typedef struct packed {
        logic wb_en;
        logic sw_brk;
        logic ic_en;
        logic dc_en;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{wb_en: 1'b1, sw_brk: 1'b1, ic_en: 1'b0, dc_en: 1'b0};

endpackage

// File: rtl/clc_regbank.sv
`timescale 1ns/1ps
module clc_regbank
    import cache_lock_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int LEVEL_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output cfg_t                     cfg,
    output logic [(1<<LEVEL_W)-1:0]  mask
);
    localparam int MASK_W = 1 << LEVEL_W;

    typedef struct packed {
        cfg_t              cfg;
        logic [MASK_W-1:0] mask;
    } state_t;

    state_t st_d, st_q;

    logic hit_cfg, hit_mask;
    assign hit_cfg  = (addr == ADDR_W'(OFF_CFG));
    assign hit_mask = (addr == ADDR_W'(OFF_MASK));

    always_comb begin
        st_d = st_q;
        if (wr_en && hit_cfg) begin
            st_d.cfg.wb_en  = wdata[CFG_WB_POS];
            st_d.cfg.sw_brk = wdata[CFG_SB_POS];
            st_d.cfg.ic_en  = wdata[CFG_IC_POS];
            st_d.cfg.dc_en  = wdata[CFG_DC_POS];
        end
        if (wr_en && hit_mask) begin
            st_d.mask = wdata[MASK_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg  <= CFG_RESET;
            st_q.mask <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    assign cfg  = st_q.cfg;
    assign mask = st_q.mask;

endmodule

// File: rtl/clc_lock_sel.sv
`timescale 1ns/1ps
module clc_lock_sel #(
    parameter int LEVEL_W  = 3,
    parameter int N_CACHE  = 2
) (
    input  logic [(1<<LEVEL_W)-1:0] mask,
    input  logic [LEVEL_W-1:0]      level,
    input  logic [N_CACHE-1:0]      cache_en,
    output logic [N_CACHE-1:0]      lock
);
    logic level_hit;
    assign level_hit = mask[level];

    for (genvar g = 0; g < N_CACHE; g++) begin : g_cache
        assign lock[g] = cache_en[g] & level_hit;
    end

endmodule

// File: rtl/clc_rd_mux.sv
`timescale 1ns/1ps
module clc_rd_mux
    import cache_lock_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int LEVEL_W = 3
) (
    input  logic [ADDR_W-1:0]        addr,
    input  cfg_t                     cfg,
    input  logic [(1<<LEVEL_W)-1:0]  mask,
    input  logic                     ic_locked,
    input  logic                     dc_locked,
    output logic [DATA_W-1:0]        rdata
);
    localparam int MASK_W = 1 << LEVEL_W;

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFF_CFG)) begin
            rdata[CFG_WB_POS] = cfg.wb_en;
            rdata[CFG_SB_POS] = cfg.sw_brk;
            rdata[CFG_IC_POS] = cfg.ic_en;
            rdata[CFG_DC_POS] = cfg.dc_en;
        end else if (addr == ADDR_W'(OFF_MASK)) begin
            rdata[MASK_W-1:0] = mask;
        end else if (addr == ADDR_W'(OFF_STAT)) begin
            rdata[STAT_IC_POS] = ic_locked;
            rdata[STAT_DC_POS] = dc_locked;
        end
    end

endmodule

// File: rtl/cache_lock_ctrl.sv
`timescale 1ns/1ps
module cache_lock_ctrl
    import cache_lock_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int LEVEL_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [LEVEL_W-1:0] int_level,
    output logic               icache_en,
    output logic               dcache_en,
    output logic               wbuf_en,
    output logic               swbrk_en,
    output logic               icache_lock,
    output logic               dcache_lock
);
    localparam int MASK_W = 1 << LEVEL_W;

    cfg_t                cfg;
    logic [MASK_W-1:0]   lock_mask;
    logic [N_CACHES-1:0] cache_en;
    logic [N_CACHES-1:0] cache_lock;

    clc_regbank #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LEVEL_W(LEVEL_W)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(bus_wr),
        .addr (bus_addr),
        .wdata(bus_wdata),
        .cfg  (cfg),
        .mask (lock_mask)
    );

    assign cache_en[CACHE_I] = cfg.ic_en;
    assign cache_en[CACHE_D] = cfg.dc_en;

    clc_lock_sel #(
        .LEVEL_W(LEVEL_W),
        .N_CACHE(N_CACHES)
    ) u_sel (
        .mask    (lock_mask),
        .level   (int_level),
        .cache_en(cache_en),
        .lock    (cache_lock)
    );

    clc_rd_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LEVEL_W(LEVEL_W)
    ) u_rd (
        .addr     (bus_addr),
        .cfg      (cfg),
        .mask     (lock_mask),
        .ic_locked(cache_lock[CACHE_I]),
        .dc_locked(cache_lock[CACHE_D]),
        .rdata    (bus_rdata)
    );

    assign icache_en   = cfg.ic_en;
    assign dcache_en   = cfg.dc_en;
    assign wbuf_en     = cfg.wb_en;
    assign swbrk_en    = cfg.sw_brk;
    assign icache_lock = cache_lock[CACHE_I];
    assign dcache_lock = cache_lock[CACHE_D];

endmodule

// File: rtl/clc_checker.sv
`timescale 1ns/1ps
module clc_checker
    import cache_lock_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int LEVEL_W = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [DATA_W-1:0]        bus_wdata,
    input logic [DATA_W-1:0]        bus_rdata,
    input logic [LEVEL_W-1:0]       int_level,
    input logic                     icache_en,
    input logic                     dcache_en,
    input logic                     icache_lock,
    input logic                     dcache_lock,
    input logic [(1<<LEVEL_W)-1:0]  lock_mask
);
    localparam int MASK_W = 1 << LEVEL_W;
    localparam logic [DATA_W-1:0] CFG_KEEP =
        (DATA_W'(1) << CFG_WB_POS) | (DATA_W'(1) << CFG_SB_POS) |
        (DATA_W'(1) << CFG_IC_POS) | (DATA_W'(1) << CFG_DC_POS);

    logic at_cfg, at_mask, at_stat;
    assign at_cfg  = (bus_addr == ADDR_W'(OFF_CFG));
    assign at_mask = (bus_addr == ADDR_W'(OFF_MASK));
    assign at_stat = (bus_addr == ADDR_W'(OFF_STAT));

    AST_CFG_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        at_cfg |-> ((bus_rdata & ~CFG_KEEP) == '0)); // R2

    AST_MASK_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_mask) |=> (lock_mask == $past(bus_wdata[MASK_W-1:0]))); // R4

    AST_ILOCK_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        icache_lock == (icache_en && lock_mask[int_level])); // R5

    AST_DLOCK_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        dcache_lock == (dcache_en && lock_mask[int_level])); // R5

    AST_STAT_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        at_stat |-> (bus_rdata == ((DATA_W'(icache_lock) << STAT_IC_POS) |
                                   (DATA_W'(dcache_lock) << STAT_DC_POS)))); // R8

    AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && at_stat) |=> ($stable(lock_mask) && $stable(icache_en) && $stable(dcache_en))); // R8

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!at_cfg && !at_mask && !at_stat) |-> (bus_rdata == '0)); // R9

    AST_DISABLED_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!icache_en |-> !icache_lock) and (!dcache_en |-> !dcache_lock)); // R10

endmodule

bind cache_lock_ctrl clc_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LEVEL_W(LEVEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .int_level  (int_level),
    .icache_en  (icache_en),
    .dcache_en  (dcache_en),
    .icache_lock(icache_lock),
    .dcache_lock(dcache_lock),
    .lock_mask  (lock_mask)
);

// File: tb/cache_lock_ctrl_test.sv
`timescale 1ns/1ps
module cache_lock_ctrl_test;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int LEVEL_W = 3;
    localparam int NLVL    = 1 << LEVEL_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [LEVEL_W-1:0] int_level = '0;
    logic icache_en, dcache_en, wbuf_en, swbrk_en, icache_lock, dcache_lock;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cache_lock_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEVEL_W(LEVEL_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .int_level(int_level),
        .icache_en(icache_en), .dcache_en(dcache_en), .wbuf_en(wbuf_en),
        .swbrk_en(swbrk_en), .icache_lock(icache_lock), .dcache_lock(dcache_lock)
    );

    // Vector: [14:7] mask, [6:4] level, [3] icache enable, [2] dcache enable,
    //         [1] expected icache lock, [0] expected dcache lock
    localparam int NVEC = 8;
    localparam logic [14:0] VEC [NVEC] = '{
        {8'h02, 3'd1, 4'b1111},
        {8'h02, 3'd2, 4'b1100},
        {8'h80, 3'd7, 4'b1010},
        {8'h80, 3'd7, 4'b0101},
        {8'hFF, 3'd0, 4'b1111},
        {8'h00, 3'd5, 4'b1100},
        {8'h55, 3'd4, 4'b1111},
        {8'h55, 3'd3, 4'b1100}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DATA_W-1:0] rd;
        logic [7:0] m;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(8'h00, rd); check("R1 cfg reset", rd, 32'h104);
        bus_read(8'h08, rd); check("R1 mask reset", rd, 32'h0);
        bus_read(8'h0C, rd); check("R1 status reset", rd, 32'h0);
        check("R1 pins reset", {26'd0, wbuf_en, swbrk_en, icache_en, dcache_en, icache_lock, dcache_lock},
              32'b110000);

        // R9 unmapped offsets
        bus_read(8'h04, rd); check("R9 read 0x04", rd, 0);
        bus_read(8'h18, rd); check("R9 read 0x18", rd, 0);
        bus_read(8'h60, rd); check("R9 read 0x60", rd, 0);

        // R2 / R3 / R4 reserved bits
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_read(8'h00, rd); check("R2 cfg all-ones", rd, 32'h107);
        check("R3 pins all set", {28'd0, wbuf_en, swbrk_en, icache_en, dcache_en}, 32'hF);
        bus_write(8'h00, 32'h0000_0002);
        check("R3 pins icache only", {28'd0, wbuf_en, swbrk_en, icache_en, dcache_en}, 32'h2);
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_read(8'h08, rd); check("R4 mask upper zero", rd, 32'hFF);

        // R8 status write ignored, R9 unmapped write ignored
        bus_write(8'h08, 32'h0);
        bus_write(8'h00, 32'h107);
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_read(8'h0C, rd); check("R8 status write ignored", rd, 0);
        bus_read(8'h08, rd); check("R8 mask untouched", rd, 0);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h60, 32'hFFFF_FFFF);
        bus_read(8'h00, rd); check("R9 cfg untouched", rd, 32'h107);
        bus_read(8'h08, rd); check("R9 mask untouched", rd, 0);
        bus_read(8'h04, rd); check("R9 0x04 still zero", rd, 0);

        // Table walk (R5, R8, R10)
        for (int i = 0; i < NVEC; i++) begin
            bus_write(8'h00, 32'h104 | {30'd0, VEC[i][3], VEC[i][2]});
            bus_write(8'h08, {24'd0, VEC[i][14:7]});
            int_level = VEC[i][6:4];
            bus_read(8'h0C, rd);
            check("R5 lock pins", {30'd0, icache_lock, dcache_lock}, {30'd0, VEC[i][1:0]});
            check("R8 status bits", rd, {30'd0, VEC[i][1:0]});
        end

        // R10 disabled cache with full mask
        bus_write(8'h00, 32'h001);
        bus_write(8'h08, 32'hFF);
        int_level = 3'd6;
        bus_read(8'h0C, rd);
        check("R10 icache disabled pin", {31'd0, icache_lock}, 0);
        check("R10 status with icache disabled", rd, 32'h1);

        // R7 all-ones and all-zeros masks at every level
        bus_write(8'h00, 32'h107);
        for (int l = 0; l < NLVL; l++) begin
            int_level = LEVEL_W'(l);
            #1;
            check("R7 mask 0xFF locks", {30'd0, icache_lock, dcache_lock}, 32'h3);
        end
        bus_write(8'h08, 32'h00);
        for (int l = 0; l < NLVL; l++) begin
            int_level = LEVEL_W'(l);
            #1;
            check("R7 mask 0x00 unlocks", {30'd0, icache_lock, dcache_lock}, 32'h0);
        end

        // R6 nesting: lock drops at a higher level and returns
        bus_write(8'h08, 32'h02);
        int_level = 3'd1; #1;
        check("R6 locked at base level", {31'd0, icache_lock}, 1);
        int_level = 3'd4; #1;
        check("R6 released at nested level", {30'd0, icache_lock, dcache_lock}, 0);
        int_level = 3'd1; #1;
        check("R6 re-engaged on return", {30'd0, icache_lock, dcache_lock}, 3);

        // R11 write lands at the sampling edge
        int_level = 3'd0;
        @(negedge clk);
        bus_addr = 8'h08; bus_wdata = 32'h01; bus_wr = 1'b1;
        #1;
        check("R11 old mask before edge", {31'd0, icache_lock}, 0);
        @(negedge clk);
        bus_wr = 1'b0;
        check("R11 new mask after edge", {31'd0, icache_lock}, 1);

        // Random sweep of all levels (R5)
        for (int r = 0; r < 40; r++) begin
            m = 8'($urandom);
            bus_write(8'h08, {24'd0, m});
            for (int l = 0; l < NLVL; l++) begin
                int_level = LEVEL_W'(l);
                bus_read(8'h0C, rd);
                check("R5 random sweep", rd, {30'd0, m[l], m[l]});
            end
        end

        finish_run();
    end

endmodule